// File: doc/BRIEF.md
# Carrier-Sense Status Stream Combiner

This block turns the carrier-sense state of a repeater slice into a continuous serial status stream. It sends one bit per clock. The slice has one attachment-unit port, which reports a carrier-sense bit and a collision-indicator bit, and four twisted-pair ports, which each report a carrier-sense bit. A standalone device, or the upstream device of a cascaded pair, sends a short frame that describes only itself.

In a cascaded pair the downstream device receives the upstream device's stream on a serial input. It merges that stream into one longer frame. The upstream device's attachment-unit bits replace its own. It then adds its own twisted-pair bits, followed by the upstream device's twisted-pair bits. The downstream device's own attachment-unit state is never sent.

Frames follow each other with no gap and no marker. Both devices take their frame alignment from the end of a shared reset. The role of the device is strapped on an input and captured while reset is held.

Top module: `csc_status_combiner`

## Requirements
- R1: While reset is low, and for the whole first frame after reset, `stat_o` is 0. The clock cycle right after the last reset edge is bit position 0 of a frame.
- R2: The role is captured from `role_cfg_i` on every clock edge while `rst_n` is low. Any change of `role_cfg_i` after reset has no effect on the stream.
- R3: Roles 2'b00 (standalone) and 2'b01 (upstream) send a 6-bit frame. Bit positions 0 to 5 carry, in order: AUI collision, AUI carrier, TP0, TP1, TP2, TP3. Frames repeat back to back.
- R4: All bits of a frame come from one snapshot of the inputs. The snapshot is taken at the clock edge that starts bit position 0. Input changes later in the frame do not alter that frame.
- R5: Role 2'b10 (downstream) sends a 10-bit frame. Positions 0 and 1 carry the upstream AUI collision bit and the upstream AUI carrier bit. Positions 2 to 5 carry the device's own TP0 to TP3. Positions 6 to 9 carry the upstream TP0 to TP3.
- R6: In role 2'b10, the values of `aui_cs_i` and `aui_ci_i` never affect `stat_o`.
- R7: In role 2'b10, `casc_i` is read as back-to-back 6-bit frames. Their bit order is the one given in R3, and the first one starts at the first cycle after reset. Each downstream frame uses the last upstream frame that completed before the frame's snapshot edge.
- R8: Role 2'b11 behaves exactly like role 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock of the status stream |
| rst_n | input | 1 | Synchronous active-low reset; also sets frame alignment |
| role_cfg_i | input | 2 | Role strap, captured during reset |
| aui_cs_i | input | 1 | Attachment-unit port carrier sense |
| aui_ci_i | input | 1 | Attachment-unit port collision indicator |
| tp_cs_i | input | 4 | Twisted-pair port carrier sense, bit n for port n |
| casc_i | input | 1 | Serial status stream from the upstream device |
| stat_o | output | 1 | Serial status stream out |

## Verification
The hardest case is the edge where a downstream frame starts at the same moment as an upstream frame finishes arriving. This happens only once every 30 cycles, and only if the two frame counters have stayed aligned since reset. The stimulus keeps the downstream role running for well over 100 cycles with random serial input, so several such coincidences occur. A reference model then checks that the older completed upstream frame is the one used. Inputs are also re-randomised every cycle, so a snapshot taken at the wrong edge, or a leak of the device's own attachment-unit bits, shows up as a bit error.

// File: rtl/csc_pkg.sv
// Package: shared role encoding and frame geometry for the status combiner.
// Assumes a fixed count of twisted-pair ports, given by each user as a parameter.
package csc_pkg;
    typedef enum logic [1:0] {
        ROLE_SOLO = 2'b00,
        ROLE_UP   = 2'b01,
        ROLE_DOWN = 2'b10,
        ROLE_RSVD = 2'b11
    } role_t;

    // Length of a frame that describes one device.
    function automatic int local_len(input int n_tp);
        return n_tp + 2;
    endfunction

    // Length of the merged frame sent by a downstream device.
    function automatic int merged_len(input int n_tp);
        return 2 * n_tp + 2;
    endfunction
endpackage

// File: rtl/csc_frame_ctr.sv
// Module: bit-position counter that wraps after a selectable last position.
// Assumes last_i is only changed while reset is held.
module csc_frame_ctr #(
    parameter int POS_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] last_i,
    output logic [POS_W-1:0] pos_o,
    output logic             wrap_o
);
    logic [POS_W-1:0] pos_q;

    // Step through the bit positions and return to 0 after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)              pos_q <= '0;
        else if (pos_q >= last_i) pos_q <= '0;
        else                     pos_q <= pos_q + 1'b1;
    end

    assign pos_o  = pos_q;
    assign wrap_o = (pos_q == last_i);

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= last_i);
    // R3
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == last_i) |=> (pos_q == '0));
endmodule

// File: rtl/csc_cascade_rx.sv
// Module: collects the upstream serial frame bit by bit. Once a frame is
// complete it is kept in a hold register.
// Assumes pos_i and wrap_i come from a counter that is aligned to reset.
module csc_cascade_rx #(
    parameter int NUM_TP = 4,
    parameter int POS_W  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   ser_i,
    input  logic [POS_W-1:0]                       pos_i,
    input  logic                                   wrap_i,
    output logic [csc_pkg::local_len(NUM_TP)-1:0]  hold_o
);
    localparam int LOC_W = csc_pkg::local_len(NUM_TP);

    logic [LOC_W-1:0] shreg_q;
    logic [LOC_W-1:0] hold_q;

    // One capture flop per bit position of the incoming frame.
    for (genvar i = 0; i < LOC_W; i++) begin : g_cap
        always_ff @(posedge clk) begin
            if (!rst_n)                    shreg_q[i] <= 1'b0;
            else if (pos_i == POS_W'(i))   shreg_q[i] <= ser_i;
        end
    end

    // Copy the frame into the hold register as its last bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (wrap_i) hold_q <= {ser_i, shreg_q[LOC_W-2:0]};
    end

    assign hold_o = hold_q;

    // R7
    hold_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (hold_q[LOC_W-1] == $past(ser_i)));
    // R7
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_i |=> $stable(hold_q));
endmodule

// File: rtl/csc_status_combiner.sv
// Module: top of the carrier-sense status stream combiner. It captures the
// role during reset, snapshots the port status at each frame start and shifts
// the frame out one bit per clock. A downstream device merges the upstream
// stream into its own frame.
// Assumes both devices of a pair share clk and leave reset on the same edge.
module csc_status_combiner #(
    parameter int NUM_TP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        role_cfg_i,
    input  logic              aui_cs_i,
    input  logic              aui_ci_i,
    input  logic [NUM_TP-1:0] tp_cs_i,
    input  logic              casc_i,
    output logic              stat_o
);
    import csc_pkg::*;

    localparam int LOC_W = local_len(NUM_TP);
    localparam int SEC_W = merged_len(NUM_TP);
    localparam int POS_W = $clog2(SEC_W);

    role_t            role_q;
    logic             is_down;
    logic [POS_W-1:0] tx_last;
    logic [POS_W-1:0] tx_pos;
    logic             tx_wrap;
    logic [POS_W-1:0] rx_pos;
    logic             rx_wrap;
    logic [LOC_W-1:0] up_hold;
    logic [SEC_W-1:0] frm_q;
    logic [SEC_W-1:0] frm_d;
    logic             stat_d;

    // Capture the role strap while reset is held, and keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) role_q <= role_t'(role_cfg_i);
    end

    assign is_down = (role_q == ROLE_DOWN);
    assign tx_last = is_down ? POS_W'(SEC_W - 1) : POS_W'(LOC_W - 1);

    csc_frame_ctr #(.POS_W(POS_W)) u_tx_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_i (tx_last),
        .pos_o  (tx_pos),
        .wrap_o (tx_wrap)
    );

    csc_frame_ctr #(.POS_W(POS_W)) u_rx_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .last_i (POS_W'(LOC_W - 1)),
        .pos_o  (rx_pos),
        .wrap_o (rx_wrap)
    );

    csc_cascade_rx #(.NUM_TP(NUM_TP), .POS_W(POS_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .ser_i  (casc_i),
        .pos_i  (rx_pos),
        .wrap_i (rx_wrap),
        .hold_o (up_hold)
    );

    // Build the next frame snapshot for the current role.
    always_comb begin
        if (is_down)
            frm_d = {up_hold[LOC_W-1:2], tp_cs_i, up_hold[1], up_hold[0]};
        else
            frm_d = {{NUM_TP{1'b0}}, tp_cs_i, aui_cs_i, aui_ci_i};
    end

    // Load the snapshot on the edge that starts bit position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       frm_q <= '0;
        else if (tx_wrap) frm_q <= frm_d;
    end

    // Pick the frame bit for the current position.
    always_comb begin
        stat_d = 1'b0;
        for (int i = 0; i < SEC_W; i++)
            if (tx_pos == POS_W'(i)) stat_d = frm_q[i];
    end

    assign stat_o = stat_d;

    // R2
    role_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(role_q));
    // R4
    frame_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_wrap |=> $stable(frm_q));
    // R3
    short_frame_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !is_down |-> (frm_q[SEC_W-1:LOC_W] == '0));
    // R7
    counters_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pos == '0) |-> (rx_pos == '0) || is_down);
endmodule

// File: tb/csc_status_combiner_tb.sv
module csc_status_combiner_tb;
    localparam int NTP = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     role_cfg = 2'b00;
    logic           aui_cs = 1'b0, aui_ci = 1'b0, casc = 1'b0;
    logic [NTP-1:0] tp_cs = '0;
    logic           stat;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    csc_status_combiner #(.NUM_TP(NTP)) u_dut (
        .clk(clk), .rst_n(rst_n), .role_cfg_i(role_cfg),
        .aui_cs_i(aui_cs), .aui_ci_i(aui_ci), .tp_cs_i(tp_cs),
        .casc_i(casc), .stat_o(stat)
    );

    // Reference model built from the requirements.
    logic [1:0] m_role;
    int         m_pos, m_rxpos;
    logic [9:0] m_frm;
    logic [5:0] m_rxsh, m_hold;

    function automatic logic [9:0] exp_frame(input logic [1:0] role, input logic [5:0] hold,
                                             input logic [3:0] tp, input logic cs, input logic ci);
        if (role == 2'b10) return {hold[5:2], tp, hold[1], hold[0]};   // R5, R6
        return {4'b0, tp, cs, ci};                                       // R3, R8
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_role = role_cfg; m_pos = 0; m_frm = '0;
            m_rxpos = 0; m_rxsh = '0; m_hold = '0;
        end else begin
            int last;
            last = (m_role == 2'b10) ? 9 : 5;
            if (m_pos == last) begin
                m_frm = exp_frame(m_role, m_hold, tp_cs, aui_cs, aui_ci);
                m_pos = 0;
            end else m_pos = m_pos + 1;
            if (m_rxpos == 5) begin
                m_hold = {casc, m_rxsh[4:0]};
                m_rxpos = 0;
            end else begin
                m_rxsh[m_rxpos] = casc;
                m_rxpos = m_rxpos + 1;
            end
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: stat_o=%b expected %b (pos %0d)", tag, act, exp, m_pos);
        end
    endtask

    task automatic do_reset(input logic [1:0] role);
        @(negedge clk);
        rst_n = 1'b0; role_cfg = role;
        repeat (3) begin
            @(negedge clk);
            check("R1", stat, 1'b0);
        end
        rst_n = 1'b1;
    endtask

    task automatic randomize_inputs();
        aui_cs = 1'($urandom); aui_ci = 1'($urandom);
        tp_cs = 4'($urandom); casc = 1'($urandom);
    endtask

    task automatic run(input int cycles, input string tag_lo, input string tag_hi);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (c < 6 && m_frm == '0) check("R1", stat, m_frm[m_pos]);
            else if (m_pos < 2) check(tag_lo, stat, m_frm[m_pos]);
            else check(tag_hi, stat, m_frm[m_pos]);
            randomize_inputs();
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        // Directed: standalone role with fixed pattern, AUI collision only.
        do_reset(2'b00);
        aui_ci = 1'b1; tp_cs = 4'b1010;
        for (int c = 0; c < 18; c++) begin
            @(negedge clk);
            check("R3", stat, m_frm[m_pos]);
        end
        run(60, "R3", "R4");            // standalone, inputs change every cycle
        do_reset(2'b01);
        run(60, "R3", "R4");            // upstream role
        do_reset(2'b10);
        run(130, "R6", "R7");           // downstream: 130 cycles cross several 30-cycle coincidences
        role_cfg = 2'b00;               // change strap after reset: must be ignored
        run(50, "R2", "R5");
        do_reset(2'b11);
        run(40, "R8", "R8");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule